// File: doc/BRIEF.md
# Predicated In-Place Tree Reducer

The block sums a short vector of integer elements kept in its own lane storage. Software first writes the elements through a load port. It then presents a vector length and a predicate mask, and pulses `start`. The block walks a binary reduction tree one layer at a time and issues at most one addition per clock. When it finishes, the total of all active lanes sits in the lowest active lane. Results go back into the lane that supplied the first operand, and no element is ever copied to another lane.

Some lanes have no active partner at a given layer. The value of such a lane stays where it is. A small per-position index map records where that value now lives, so later layers read it from that lane. Each addition shows its (first, second) lane pair on the issue outputs, which makes the schedule observable. The schedule depends only on the vector length and the mask, so the same inputs always produce the same sequence and the same latency.

Top module: `ptree_reduce`

## Requirements
- R1: While idle, a load pulse writes `ld_data` into lane `ld_idx`. A load pulse while busy is ignored. `rd_data` always shows the current content of lane `rd_idx`, and all lanes read 0 after reset.
- R2: A `start` seen while idle raises `busy` from the next cycle. `busy` stays high up to and including the single cycle in which `done` is high, and drops in the cycle after that. A `start` seen while busy is ignored, including its length and mask.
- R3: The vector length is clamped to the lane count. Lanes at or beyond the clamped length are inactive whatever their mask bit says. Every issued operation names only lanes that are active in the mask captured at start.
- R4: At completion the lowest active lane holds the sum, modulo 2^DW, of the values that all active lanes held at start.
- R5: Lanes that are not active keep their values through a reduction.
- R6: Layers use half-spans 1, 2, 4 and so on, while the half-span is below the length. Within a layer, groups are visited one per cycle in ascending order of their base position i. A group issues (first, second) only when both logical positions i and i+half hold live values. `first` is the lane where position i's value lives, `second` is the lane where position i+half's value lives, first < second, and the sum is written to `first`.
- R7: If position i holds nothing but i+half does, position i takes over the lane of i+half without any data move, and later layers fetch from that lane. Example: length 4 with mask 0b1010 issues exactly one operation, (1, 3).
- R8: With zero or one active lane the block completes without issuing any operation and without changing any lane.
- R9: `done` is high in cycle G+1 after the start edge. G is the total number of groups, the sum over layers of ceil(length/(2*half)). For a clamped length of 0 or 1, G is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for one lane |
| ld_idx | input | $clog2(LANES) | Lane to load |
| ld_data | input | DW | Value to load |
| vec_len | input | $clog2(LANES)+1 | Vector length, sampled with start |
| pred_mask | input | LANES | Active-lane mask, sampled with start |
| start | input | 1 | Begin a reduction when idle |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| iss_valid | output | 1 | An addition is issued this cycle |
| iss_first | output | $clog2(LANES) | Lane of the first operand and of the result |
| iss_second | output | $clog2(LANES) | Lane of the second operand |
| rd_idx | input | $clog2(LANES) | Lane to read |
| rd_data | output | DW | Content of lane rd_idx |

## Verification
The bench builds the block with 8 lanes of 8-bit data. With this width, random sums wrap often, so the modulo behaviour of R4 is exercised on most runs rather than by a rare corner. The 4-bit length input can present values from 0 to 15, which covers every length below, at and above the lane count, including the clamp. Eight lanes give three tree layers, enough to produce chains of inherited positions across two layers.

// File: rtl/ptree_pkg.sv
package ptree_pkg;

    // Controller phases of the reducer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ptree_state_e;

endpackage

// File: rtl/ptree_sched.sv
module ptree_sched
    import ptree_pkg::*;
#(
    parameter int LANES = 16,
    localparam int IW = $clog2(LANES),
    localparam int CW = IW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IW:0]      vl_in,
    input  logic [LANES-1:0] mask_in,
    output logic             busy,
    output logic             done,
    output logic             iss_valid,
    output logic [IW-1:0]    iss_first,
    output logic [IW-1:0]    iss_second
);

    typedef struct packed {
        ptree_state_e              st;
        logic [CW-1:0]             vl;    // clamped length
        logic [CW-1:0]             half;  // half-span of the current layer
        logic [CW-1:0]             grp;   // base position of the current group
        logic [LANES-1:0]          live;  // logical position holds a value
        logic [LANES-1:0][IW-1:0]  loc;   // lane where that value lives
    } sched_t;

    sched_t        s_d, s_q;
    logic [CW-1:0] vl_eff;
    logic [CW-1:0] partner;
    logic [CW-1:0] span;
    logic [CW-1:0] next_grp;
    logic [IW-1:0] lo_pos, hi_pos;
    logic          lo_live, hi_live;

    assign vl_eff = (CW'(vl_in) > CW'(LANES)) ? CW'(LANES) : CW'(vl_in);  // R3 clamp

    always_comb begin
        s_d      = s_q;
        partner  = s_q.grp + s_q.half;
        span     = s_q.half << 1;
        next_grp = s_q.grp + span;
        lo_pos   = s_q.grp[IW-1:0];
        hi_pos   = partner[IW-1:0];
        lo_live  = s_q.live[lo_pos];
        hi_live  = (partner < s_q.vl) && s_q.live[hi_pos];

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.vl   = vl_eff;
                    s_d.half = CW'(1);
                    s_d.grp  = '0;
                    for (int k = 0; k < LANES; k++) begin
                        s_d.live[k] = mask_in[k] && (CW'(k) < vl_eff);  // R3
                        s_d.loc[k]  = IW'(k);
                    end
                    s_d.st = (vl_eff <= CW'(1)) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                // R7: an empty lower position inherits the upper one's lane
                if (hi_live && !lo_live) begin
                    s_d.loc[lo_pos] = s_q.loc[hi_pos];
                end
                if (hi_live) begin
                    s_d.live[lo_pos] = 1'b1;
                end
                // R6: one group per cycle, layers double the half-span
                if (next_grp >= s_q.vl) begin
                    s_d.grp  = '0;
                    s_d.half = span;
                    if (span >= s_q.vl) begin
                        s_d.st = ST_FIN;
                    end
                end else begin
                    s_d.grp = next_grp;
                end
            end
            ST_FIN: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign done       = (s_q.st == ST_FIN);
    assign iss_valid  = (s_q.st == ST_RUN) && lo_live && hi_live;
    assign iss_first  = s_q.loc[lo_pos];
    assign iss_second = s_q.loc[hi_pos];

endmodule

// File: rtl/ptree_lanes.sv
module ptree_lanes #(
    parameter int LANES = 16,
    parameter int DW    = 16,
    localparam int IW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          acc_en,
    input  logic [IW-1:0] acc_first,
    input  logic [IW-1:0] acc_second,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] cells [LANES];
    logic [DW-1:0] acc_sum;

    // One shared adder; result returns to the first operand's lane (R6)
    assign acc_sum = cells[acc_first] + cells[acc_second];
    assign rd_data = cells[rd_idx];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (ld_en && (ld_idx == IW'(g))) begin
                cell_d = ld_data;                 // R1
            end else if (acc_en && (acc_first == IW'(g))) begin
                cell_d = acc_sum;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign cells[g] = cell_q;
    end

endmodule

// File: rtl/ptree_reduce.sv
module ptree_reduce #(
    parameter int LANES = 16,
    parameter int DW    = 16,
    localparam int IW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IW-1:0]    ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic [IW:0]      vec_len,
    input  logic [LANES-1:0] pred_mask,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             iss_valid,
    output logic [IW-1:0]    iss_first,
    output logic [IW-1:0]    iss_second,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic ld_ok;

    assign ld_ok = ld_en && !busy;  // R1: loads dropped while reducing

    ptree_sched #(
        .LANES (LANES)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vl_in      (vec_len),
        .mask_in    (pred_mask),
        .busy       (busy),
        .done       (done),
        .iss_valid  (iss_valid),
        .iss_first  (iss_first),
        .iss_second (iss_second)
    );

    ptree_lanes #(
        .LANES (LANES),
        .DW    (DW)
    ) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_ok),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .acc_en     (iss_valid),
        .acc_first  (iss_first),
        .acc_second (iss_second),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/ptree_reduce_chk.sv
module ptree_reduce_chk #(
    parameter int LANES = 16,
    localparam int IW = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [IW:0]      vec_len,
    input logic [LANES-1:0] pred_mask,
    input logic             busy,
    input logic             done,
    input logic             iss_valid,
    input logic [IW-1:0]    iss_first,
    input logic [IW-1:0]    iss_second
);

    logic [IW:0]      len_eff;
    logic [LANES-1:0] act_now;
    logic [LANES-1:0] act_q;
    logic             sparse_q;

    assign len_eff = (int'(vec_len) > LANES) ? (IW+1)'(LANES) : vec_len;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            act_now[k] = pred_mask[k] && (k < int'(len_eff));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            sparse_q <= 1'b0;
        end else if (start && !busy) begin
            act_q    <= act_now;
            sparse_q <= ($countones(act_now) <= 1);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R2
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                          // R2
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                               // R2
    AST_ISSUE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (busy && !done));                           // R6
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_first < iss_second));                  // R6
    AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (act_q[iss_first] && act_q[iss_second]));   // R3
    AST_SPARSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sparse_q && busy) |-> !iss_valid);                       // R8

endmodule

bind ptree_reduce ptree_reduce_chk #(
    .LANES (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vec_len    (vec_len),
    .pred_mask  (pred_mask),
    .busy       (busy),
    .done       (done),
    .iss_valid  (iss_valid),
    .iss_first  (iss_first),
    .iss_second (iss_second)
);

// File: tb/sim_ptree_reduce.sv
`timescale 1ns/1ps
module sim_ptree_reduce;

    localparam int L  = 8;
    localparam int DW = 8;
    localparam int IW = $clog2(L);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [DW-1:0] ld_data = '0;
    logic [IW:0]   vec_len = '0;
    logic [L-1:0]  pred_mask = '0;
    logic          start = 1'b0;
    logic          busy, done, iss_valid;
    logic [IW-1:0] iss_first, iss_second;
    logic [IW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    logic [DW-1:0] mem     [L];
    logic [DW-1:0] exp_vec [L];
    int exp_ci [64];
    int exp_co [64];
    int exp_n;
    int exp_groups;

    always #2.5 clk = ~clk;

    ptree_reduce #(.LANES(L), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .vec_len(vec_len), .pred_mask(pred_mask), .start(start), .busy(busy), .done(done),
        .iss_valid(iss_valid), .iss_first(iss_first), .iss_second(iss_second),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [DW-1:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = IW'(idx); ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        mem[idx] = val;
    endtask

    task automatic peek(input int idx, output logic [DW-1:0] val);
        @(negedge clk);
        rd_idx = IW'(idx);
        #1 val = rd_data;
    endtask

    // Reference tree schedule derived from R6/R7
    task automatic model(input int ve, input logic [L-1:0] m);
        int loc [L];
        bit live [L];
        for (int k = 0; k < L; k++) begin
            loc[k] = k; live[k] = (k < ve) && m[k]; exp_vec[k] = mem[k];
        end
        exp_n = 0; exp_groups = 0;
        for (int h = 1; h < ve; h = h * 2) begin
            for (int i = 0; i < ve; i = i + 2 * h) begin
                int o;
                bit up;
                o = i + h;
                up = 1'b0;
                if (o < ve) up = live[o];
                exp_groups++;
                if (live[i] && up) begin
                    exp_vec[loc[i]] = exp_vec[loc[i]] + exp_vec[loc[o]];
                    exp_ci[exp_n] = loc[i]; exp_co[exp_n] = loc[o]; exp_n++;
                end else if (up) begin
                    loc[i] = loc[o];
                end
                if (up) live[i] = 1'b1;
            end
        end
    endtask

    task automatic run(input int vl, input logic [L-1:0] m, input bit poke);
        int ve, cyc, got_n, low, nact;
        int gci [64];
        int gco [64];
        logic [DW-1:0] pre [L];
        logic [DW-1:0] sum;
        logic [DW-1:0] v;
        ve = (vl > L) ? L : vl;
        for (int k = 0; k < L; k++) pre[k] = mem[k];
        model(ve, m);
        sum = '0; low = -1; nact = 0;
        for (int k = 0; k < ve; k++) begin
            if (m[k]) begin
                sum = sum + pre[k]; nact++;
                if (low < 0) low = k;
            end
        end
        @(negedge clk);
        start = 1'b1; vec_len = (IW+1)'(vl); pred_mask = m;
        @(negedge clk);
        start = 1'b0; cyc = 1; got_n = 0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        forever begin
            if (iss_valid) begin
                if (got_n < 64) begin gci[got_n] = iss_first; gco[got_n] = iss_second; end
                got_n++;
            end
            if (done || cyc > 200) break;
            chk(busy == 1'b1, "R2", "busy held until done", int'(busy), 1);
            if (poke && cyc == 2) begin
                start = 1'b1; vec_len = 3; pred_mask = 1;
                ld_en = 1'b1; ld_idx = 0; ld_data = 8'h5A;
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; ld_en = 1'b0;
        chk(cyc == exp_groups + 1, "R9", "done cycle", cyc, exp_groups + 1);
        chk(got_n == exp_n, "R6", "issue count", got_n, exp_n);
        for (int j = 0; j < exp_n && j < got_n && j < 64; j++) begin
            chk(gci[j] == exp_ci[j], "R6", "issue first", gci[j], exp_ci[j]);
            chk(gco[j] == exp_co[j], "R7", "issue second", gco[j], exp_co[j]);
        end
        if (nact <= 1) chk(got_n == 0, "R8", "no issue when sparse", got_n, 0);
        @(negedge clk);
        chk(!busy && !done, "R2", "idle after done", int'(busy) + int'(done), 0);
        for (int k = 0; k < L; k++) begin
            bit act;
            peek(k, v);
            act = (k < ve) && m[k];
            if (!act)
                chk(v == pre[k], "R5", "inactive lane kept", int'(v), int'(pre[k]));
            else if (k == low)
                chk(v == sum, "R4", "sum in lowest active", int'(v), int'(sum));
            else
                chk(v == exp_vec[k], "R6", "partial lane", int'(v), int'(exp_vec[k]));
            if (nact <= 1)
                chk(v == pre[k], "R8", "no write when sparse", int'(v), int'(pre[k]));
        end
        for (int k = 0; k < L; k++) mem[k] = exp_vec[k];
    endtask

    task automatic fill_random();
        for (int k = 0; k < L; k++) load(k, DW'($urandom));
    endtask

    initial begin
        logic [DW-1:0] v;
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int k = 0; k < L; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !iss_valid, "R2", "reset outputs", int'(busy), 0);
        for (int k = 0; k < L; k++) begin
            peek(k, v);
            chk(v == '0, "R1", "reset lane", int'(v), 0);
        end
        fill_random();
        for (int k = 0; k < L; k++) begin
            peek(k, v);
            chk(v == mem[k], "R1", "loaded lane", int'(v), int'(mem[k]));
        end
        // R7 directed: length 4, mask 0b1010 issues only (1,3)
        for (int k = 0; k < L; k++) load(k, DW'(k + 1));
        run(4, 8'b0000_1010, 1'b0);
        chk(exp_n == 1 && exp_ci[0] == 1 && exp_co[0] == 3, "R7", "reference pair", exp_ci[0], 1);
        // R8 directed: empty and single-lane masks
        fill_random();
        run(8, 8'h00, 1'b0);
        run(8, 8'h20, 1'b0);
        run(1, 8'hFF, 1'b0);
        run(0, 8'hFF, 1'b0);
        // R3 directed: mask bits beyond length, length above lane count
        fill_random();
        run(5, 8'hF8, 1'b0);
        fill_random();
        run(15, 8'hFF, 1'b0);
        // R1/R2 directed: start and load while busy are ignored
        fill_random();
        run(8, 8'hFF, 1'b1);
        // Random mix
        for (int t = 0; t < 60; t++) begin
            if ($urandom_range(0, 1) == 1) fill_random();
            run($urandom_range(0, 2 * L - 1), L'($urandom), 1'b0);
        end
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule